// File: doc/BRIEF.md
# PLL and Peripheral Clock Period Calculator

This block works out, in registered logic, the period of three PLL outputs and of two peripheral reference clocks. All values are periods, as unsigned integers. The inputs are the period of the reference clock and four control words: one for each PLL (an IO PLL, a CPU PLL and a memory PLL) and one shared peripheral clock word. The block models only the arithmetic: field decode, bypass and stop handling, source selection, division and gating. It does not produce any real clock.

Each PLL stage has three cases. In bypass it passes the reference period through unchanged. When it is held in reset or powered down, it reports 0, which means stopped. Otherwise it divides the reference period by its feedback multiplier. The peripheral word picks one PLL period through a four-way selector and multiplies that period by a 6-bit divisor. Each of the two peripheral outputs has its own enable bit that gates it. The block's reset forces every output to 0. When the inputs change, the new results appear two clock edges later, together with a one-cycle update pulse.

Top module: `clk_period_calc`

## Requirements
- R1: While `rst_n` is low, all five period outputs and `update_pulse` are 0, whatever the inputs.
- R2: A PLL whose control bit 4 (bypass) is 1 reports the reference period, even when bit 0 (reset) or bit 1 (power-down) is also 1.
- R3: A PLL with bit 4 clear and bit 0 or bit 1 set reports a period of 0.
- R4: Otherwise, a PLL reports the reference period divided by the 7-bit multiplier in control bits [18:12], with integer truncation.
- R5: A PLL with bit 4 clear, bits 0 and 1 clear and a multiplier field of 0 reports 0.
- R6: Peripheral word bits [5:4] choose the source: values 0 and 1 pick the IO PLL, 2 picks the CPU PLL and 3 picks the memory PLL.
- R7: A peripheral output period is the chosen PLL period times the divisor in peripheral bits [13:8]. A divisor of 0 acts as 1.
- R8: Peripheral output 0 is 0 when peripheral bit 0 is clear. Peripheral output 1 is 0 when peripheral bit 1 is clear. Each enable affects only its own output.
- R9: With the default saturating setting, a peripheral product that does not fit in the period width reads as all ones.
- R10: After any input change, all outputs show the new results on the second rising clock edge. `update_pulse` is 1 for exactly the cycle after that edge, and it stays 0 while the inputs are steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces all outputs to 0 |
| ref_period | input | 32 | Reference clock period |
| io_pll_ctrl | input | 32 | IO PLL control word |
| cpu_pll_ctrl | input | 32 | CPU PLL control word |
| mem_pll_ctrl | input | 32 | Memory PLL control word |
| periph_ctrl | input | 32 | Shared peripheral clock control word |
| io_pll_period | output | 32 | IO PLL output period |
| cpu_pll_period | output | 32 | CPU PLL output period |
| mem_pll_period | output | 32 | Memory PLL output period |
| periph0_period | output | 32 | Peripheral reference clock 0 period |
| periph1_period | output | 32 | Peripheral reference clock 1 period |
| update_pulse | output | 1 | One-cycle strobe marking freshly updated outputs |

## Verification
Every result comes out of the second register stage. The PLL stage and the captured peripheral word update on the first rising edge after an input change. The peripheral products, the re-registered PLL periods and the update pulse update on the second. The bench therefore drives inputs on a falling edge, lets two rising edges pass, and compares outputs on the next falling edge. At that same point it expects the pulse high. On the falling edge before it, and on the one after it, it expects the pulse low. The steady-input test holds the inputs for several cycles and checks the pulse on each of them.

// File: rtl/clk_period_pkg.sv
package clk_period_pkg;
   // control word field positions (consumed by the selector and the PLL stages)
   localparam int PLL_RST_BIT  = 0;
   localparam int PLL_PD_BIT   = 1;
   localparam int PLL_BYP_BIT  = 4;
   localparam int PLL_MUL_LSB  = 12;
   localparam int PLL_MUL_W    = 7;
   localparam int PER_SEL_LSB  = 4;
   localparam int PER_SEL_W    = 2;
   localparam int PER_DIV_LSB  = 8;
   localparam int PER_DIV_W    = 6;
   localparam int NUM_PLL      = 3;
   localparam int NUM_PER_OUT  = 2;

   typedef enum logic [PER_SEL_W-1:0] {
      SRC_IO_A = 2'd0,
      SRC_IO_B = 2'd1,
      SRC_CPU  = 2'd2,
      SRC_MEM  = 2'd3
   } src_sel_e;

   typedef enum int {
      PLL_IO  = 0,
      PLL_CPU = 1,
      PLL_MEM = 2
   } pll_idx_e;
endpackage

// File: rtl/pll_period_unit.sv
module pll_period_unit
   import clk_period_pkg::*;
#(
   parameter int PW = 32,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] in_period,
   input  logic [CW-1:0] ctrl,
   output logic [PW-1:0] period_q
);
   localparam int MUL_MSB = PLL_MUL_LSB + PLL_MUL_W - 1;

   generate
      if (CW <= MUL_MSB) begin : g_bad_cw
         $error("pll_period_unit: control width too narrow for multiplier field");
      end
      if (PW < PLL_MUL_W) begin : g_bad_pw
         $error("pll_period_unit: period width below multiplier width");
      end
   endgenerate

   logic                 byp, stop;
   logic [PLL_MUL_W-1:0] mult;
   logic [PW-1:0]        period_d;

   always_comb begin
      byp  = ctrl[PLL_BYP_BIT];
      stop = ctrl[PLL_RST_BIT] | ctrl[PLL_PD_BIT];
      mult = ctrl[MUL_MSB:PLL_MUL_LSB];
      if (byp)
         period_d = in_period;
      else if (stop || (mult == '0))
         period_d = '0;
      else
         period_d = in_period / PW'(mult);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) period_q <= '0;
      else        period_q <= period_d;
   end

   // R2
   bypass_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[PLL_BYP_BIT] |=> period_q == $past(in_period));

   // R3
   stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[PLL_BYP_BIT] && (ctrl[PLL_RST_BIT] || ctrl[PLL_PD_BIT])) |=> period_q == '0);

   // R5
   zero_mult_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[PLL_BYP_BIT] == 1'b0 && ctrl[MUL_MSB:PLL_MUL_LSB] == '0) |=> period_q == '0);
endmodule

// File: rtl/periph_period_unit.sv
module periph_period_unit #(
   parameter int PW      = 32,
   parameter int DIV_W   = 6,
   parameter int SEL_W   = 2,
   parameter bit SAT_MUL = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [(1<<SEL_W)-1:0][PW-1:0] src_periods,
   input  logic [SEL_W-1:0]          sel,
   input  logic [DIV_W-1:0]          divisor,
   input  logic                      enable,
   output logic [PW-1:0]             period_q
);
   localparam int PROD_W = PW + DIV_W;

   generate
      if (DIV_W < 1 || SEL_W < 1) begin : g_bad_cfg
         $error("periph_period_unit: divisor and select widths must be positive");
      end
   endgenerate

   logic [PW-1:0]     chosen;
   logic [DIV_W-1:0]  eff_div;
   logic [PROD_W-1:0] prod;
   logic [PW-1:0]     fitted;
   logic [PW-1:0]     period_d;

   always_comb begin
      chosen  = src_periods[sel];
      eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
      prod    = PROD_W'(chosen) * PROD_W'(eff_div);
   end

   generate
      if (SAT_MUL) begin : g_sat
         always_comb fitted = (prod[PROD_W-1:PW] != '0) ? '1 : prod[PW-1:0];
      end else begin : g_wrap
         always_comb fitted = prod[PW-1:0];
      end
   endgenerate

   always_comb period_d = enable ? fitted : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) period_q <= '0;
      else        period_q <= period_d;
   end

   // R8
   gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> period_q == '0);

   // R6
   unit_div_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && divisor == DIV_W'(1)) |=> period_q == $past(src_periods[sel]));
endmodule

// File: rtl/input_change_det.sv
module input_change_det #(
   parameter int W = 160
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic         strobe_q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("input_change_det: width must be positive");
      end
   endgenerate

   logic [W-1:0] prev_q;
   logic         chg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         chg_q    <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         prev_q   <= din;
         chg_q    <= (din != prev_q);
         strobe_q <= chg_q;
      end
   end

   // R10
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_q && $stable(din) && $past(din) == prev_q) |=> !strobe_q);
endmodule

// File: rtl/clk_period_calc.sv
module clk_period_calc
   import clk_period_pkg::*;
#(
   parameter int PW      = 32,
   parameter int CW      = 32,
   parameter bit SAT_MUL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] ref_period,
   input  logic [CW-1:0] io_pll_ctrl,
   input  logic [CW-1:0] cpu_pll_ctrl,
   input  logic [CW-1:0] mem_pll_ctrl,
   input  logic [CW-1:0] periph_ctrl,
   output logic [PW-1:0] io_pll_period,
   output logic [PW-1:0] cpu_pll_period,
   output logic [PW-1:0] mem_pll_period,
   output logic [PW-1:0] periph0_period,
   output logic [PW-1:0] periph1_period,
   output logic          update_pulse
);
   localparam int NSRC  = 1 << PER_SEL_W;
   localparam int DET_W = PW + 4 * CW;

   generate
      if (CW < PER_DIV_LSB + PER_DIV_W) begin : g_bad_cw
         $error("clk_period_calc: control width too narrow for peripheral fields");
      end
   endgenerate

   logic [NUM_PLL-1:0][CW-1:0] pll_ctrl;
   logic [NUM_PLL-1:0][PW-1:0] pll_s1;
   logic [NUM_PLL-1:0][PW-1:0] pll_s2;
   logic [NSRC-1:0][PW-1:0]    src_periods;
   logic [NUM_PER_OUT-1:0][PW-1:0] per_out;
   logic [CW-1:0]              per_ctrl_q;
   src_sel_e                   sel;

   assign pll_ctrl[PLL_IO]  = io_pll_ctrl;
   assign pll_ctrl[PLL_CPU] = cpu_pll_ctrl;
   assign pll_ctrl[PLL_MEM] = mem_pll_ctrl;

   // stage 1: PLL periods and captured peripheral word
   for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
      pll_period_unit #(.PW(PW), .CW(CW)) u_pll (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_period (ref_period),
         .ctrl      (pll_ctrl[p]),
         .period_q  (pll_s1[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) per_ctrl_q <= '0;
      else        per_ctrl_q <= periph_ctrl;
   end

   // source table: both low codes resolve to the IO PLL
   always_comb begin
      src_periods[SRC_IO_A] = pll_s1[PLL_IO];
      src_periods[SRC_IO_B] = pll_s1[PLL_IO];
      src_periods[SRC_CPU]  = pll_s1[PLL_CPU];
      src_periods[SRC_MEM]  = pll_s1[PLL_MEM];
      sel = src_sel_e'(per_ctrl_q[PER_SEL_LSB +: PER_SEL_W]);
   end

   // stage 2: peripheral outputs and aligned PLL periods
   for (genvar o = 0; o < NUM_PER_OUT; o++) begin : g_out
      periph_period_unit #(
         .PW(PW), .DIV_W(PER_DIV_W), .SEL_W(PER_SEL_W), .SAT_MUL(SAT_MUL)
      ) u_per (
         .clk         (clk),
         .rst_n       (rst_n),
         .src_periods (src_periods),
         .sel         (sel),
         .divisor     (per_ctrl_q[PER_DIV_LSB +: PER_DIV_W]),
         .enable      (per_ctrl_q[o]),
         .period_q    (per_out[o])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pll_s2 <= '0;
      else        pll_s2 <= pll_s1;
   end

   input_change_det #(.W(DET_W)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      ({ref_period, io_pll_ctrl, cpu_pll_ctrl, mem_pll_ctrl, periph_ctrl}),
      .strobe_q (update_pulse)
   );

   assign io_pll_period  = pll_s2[PLL_IO];
   assign cpu_pll_period = pll_s2[PLL_CPU];
   assign mem_pll_period = pll_s2[PLL_MEM];
   assign periph0_period = per_out[0];
   assign periph1_period = per_out[1];

   // R4
   pll_divide_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> io_pll_period == $past(pll_s1[PLL_IO]));
endmodule

// File: tb/tb_clk_period_calc.sv
`timescale 1ns/1ps
module tb_clk_period_calc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ref_period = '0;
   logic [31:0] io_pll_ctrl = '0, cpu_pll_ctrl = '0, mem_pll_ctrl = '0, periph_ctrl = '0;
   logic [31:0] io_pll_period, cpu_pll_period, mem_pll_period, periph0_period, periph1_period;
   logic        update_pulse;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   clk_period_calc dut (
      .clk(clk), .rst_n(rst_n), .ref_period(ref_period),
      .io_pll_ctrl(io_pll_ctrl), .cpu_pll_ctrl(cpu_pll_ctrl),
      .mem_pll_ctrl(mem_pll_ctrl), .periph_ctrl(periph_ctrl),
      .io_pll_period(io_pll_period), .cpu_pll_period(cpu_pll_period),
      .mem_pll_period(mem_pll_period), .periph0_period(periph0_period),
      .periph1_period(periph1_period), .update_pulse(update_pulse)
   );

   function automatic logic [31:0] pll_model(input logic [31:0] inp, input logic [31:0] c);
      logic [6:0] m;
      m = c[18:12];
      if (c[4]) return inp;
      if (c[0] || c[1]) return 32'd0;
      if (m == 7'd0) return 32'd0;
      return inp / {25'd0, m};
   endfunction

   function automatic logic [31:0] per_model(input logic [31:0] inp, input logic [31:0] io_c,
      input logic [31:0] cpu_c, input logic [31:0] mem_c, input logic [31:0] pc, input int idx);
      logic [31:0] src;
      logic [63:0] prod;
      logic [5:0]  d;
      if (!pc[idx]) return 32'd0;
      case (pc[5:4])
         2'd2:    src = pll_model(inp, cpu_c);
         2'd3:    src = pll_model(inp, mem_c);
         default: src = pll_model(inp, io_c);
      endcase
      d = (pc[13:8] == 6'd0) ? 6'd1 : pc[13:8];
      prod = {32'd0, src} * {58'd0, d};
      return (prod > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : prod[31:0];
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // drive on a falling edge, pass two rising edges, compare on the next falling edge
   task automatic apply(input logic [31:0] inp, input logic [31:0] io_c, input logic [31:0] cpu_c,
      input logic [31:0] mem_c, input logic [31:0] pc, input string req);
      @(negedge clk);
      ref_period = inp; io_pll_ctrl = io_c; cpu_pll_ctrl = cpu_c;
      mem_pll_ctrl = mem_c; periph_ctrl = pc;
      @(posedge clk);
      @(negedge clk);
      chk("R10", "pulse early", {31'd0, update_pulse}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      chk(req, "io pll",  io_pll_period,  pll_model(inp, io_c));
      chk(req, "cpu pll", cpu_pll_period, pll_model(inp, cpu_c));
      chk(req, "mem pll", mem_pll_period, pll_model(inp, mem_c));
      chk(req, "periph0", periph0_period, per_model(inp, io_c, cpu_c, mem_c, pc, 0));
      chk(req, "periph1", periph1_period, per_model(inp, io_c, cpu_c, mem_c, pc, 1));
   endtask

   function automatic logic [31:0] pllw(input bit byp, input bit rs, input bit pd, input int m);
      logic [31:0] w;
      w = '0;
      w[4] = byp; w[0] = rs; w[1] = pd;
      w[18:12] = 7'(m);
      return w;
   endfunction

   function automatic logic [31:0] perw(input bit e0, input bit e1, input int s, input int d);
      logic [31:0] w;
      w = '0;
      w[0] = e0; w[1] = e1;
      w[5:4] = 2'(s);
      w[13:8] = 6'(d);
      return w;
   endfunction

   task automatic t_reset();
      ref_period = 32'd1000; io_pll_ctrl = pllw(1, 0, 0, 0);
      periph_ctrl = perw(1, 1, 0, 1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "io in reset", io_pll_period, 32'd0);
      chk("R1", "periph0 in reset", periph0_period, 32'd0);
      chk("R1", "pulse in reset", {31'd0, update_pulse}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_bypass();
      apply(32'd1000, pllw(1, 1, 1, 26), pllw(1, 0, 0, 0), pllw(1, 0, 1, 5),
            perw(1, 1, 0, 1), "R2");
      chk("R2", "pulse due", {31'd0, update_pulse}, 32'd1);
      @(negedge clk);
      chk("R10", "pulse single", {31'd0, update_pulse}, 32'd0);
   endtask

   task automatic t_stop();
      apply(32'd1000, pllw(0, 1, 0, 10), pllw(0, 0, 1, 10), pllw(0, 1, 1, 10),
            perw(1, 1, 2, 1), "R3");
   endtask

   task automatic t_divide();
      apply(32'd1000, pllw(0, 0, 0, 26), pllw(0, 0, 0, 3), pllw(0, 0, 0, 127),
            perw(1, 1, 0, 1), "R4");
      chk("R4", "io 1000/26", io_pll_period, 32'd38);
      chk("R4", "cpu 1000/3", cpu_pll_period, 32'd333);
   endtask

   task automatic t_zero_mult();
      apply(32'd5000, pllw(0, 0, 0, 0), pllw(0, 0, 0, 0), pllw(0, 0, 0, 2),
            perw(1, 1, 3, 1), "R5");
      chk("R5", "io zero mult", io_pll_period, 32'd0);
   endtask

   task automatic t_mux();
      for (int s = 0; s < 4; s++) begin
         apply(32'd6000, pllw(0, 0, 0, 2), pllw(0, 0, 0, 3), pllw(0, 0, 0, 4),
               perw(1, 1, s, 1), "R6");
      end
      chk("R6", "sel3 mem", periph0_period, 32'd1500);
   endtask

   task automatic t_divisor();
      apply(32'd100, pllw(1, 0, 0, 0), pllw(0, 0, 0, 1), pllw(0, 0, 0, 1),
            perw(1, 1, 1, 0), "R7");
      chk("R7", "divisor 0 as 1", periph0_period, 32'd100);
      apply(32'd100, pllw(1, 0, 0, 0), pllw(0, 0, 0, 1), pllw(0, 0, 0, 1),
            perw(1, 1, 0, 63), "R7");
      chk("R7", "divisor 63", periph1_period, 32'd6300);
   endtask

   task automatic t_enable();
      apply(32'd400, pllw(0, 0, 0, 2), pllw(0, 0, 0, 1), pllw(0, 0, 0, 1),
            perw(1, 0, 0, 5), "R8");
      chk("R8", "only out1 off", periph1_period, 32'd0);
      chk("R8", "out0 on", periph0_period, 32'd1000);
      apply(32'd400, pllw(0, 0, 0, 2), pllw(0, 0, 0, 1), pllw(0, 0, 0, 1),
            perw(0, 1, 0, 5), "R8");
      chk("R8", "only out0 off", periph0_period, 32'd0);
      chk("R8", "out1 on", periph1_period, 32'd1000);
   endtask

   task automatic t_saturate();
      apply(32'hF000_0000, pllw(1, 0, 0, 0), pllw(0, 0, 0, 1), pllw(0, 0, 0, 1),
            perw(1, 1, 0, 63), "R9");
      chk("R9", "clamped", periph0_period, 32'hFFFF_FFFF);
   endtask

   task automatic t_steady();
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk("R10", "steady no pulse", {31'd0, update_pulse}, 32'd0);
      end
      apply(32'd777, pllw(0, 0, 0, 7), pllw(0, 0, 0, 7), pllw(0, 0, 0, 7),
            perw(1, 1, 2, 2), "R10");
      chk("R10", "pulse on change", {31'd0, update_pulse}, 32'd1);
      @(negedge clk);
      chk("R10", "pulse ends", {31'd0, update_pulse}, 32'd0);
   endtask

   task automatic t_mid_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "async clear periph1", periph1_period, 32'd0);
      chk("R1", "async clear mem", mem_pll_period, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "recovered periph1", periph1_period, 32'd222);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_bypass();
      t_stop();
      t_divide();
      t_zero_mult();
      t_mux();
      t_divisor();
      t_enable();
      t_saturate();
      t_steady();
      t_mid_reset();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule